// File: doc/BRIEF.md
# Sprite-Zero Hit Flag Predictor

This block keeps the status bit that tells software when the first opaque pixel of sprite zero lands on an opaque background pixel. It does not composite pixels. It turns the hit coordinate, which a neighbouring block supplies, into the CPU cycle at which the hit happens within the frame. It then compares the running CPU cycle count against that cycle whenever software reads status.

The prediction is lazy. Nothing is computed until the first status read of a frame. That read starts a short serial sequence: one cycle forms the pixel-clock product, and then a bit-serial divider divides it by the number of pixel clocks per CPU clock. The result is stored. Later reads compare against it in a single cycle.

A rendering change in the middle of a frame throws away the stored prediction while the flag is still clear, so the next read recomputes it. Once the flag is set it stays set until the frame restarts. A no-hit input, asserted when sprite zero can never collide in this frame, keeps the flag clear.

Top module: `ozp_hit_predictor`

## Requirements
- R1: After reset, `hit_flag` and `rd_ready` are both 0.
- R2: With no stored prediction and `obj_absent` low, a read computes P = ((obj_y + 21) * 341 + obj_x) div 3. After that read, `hit_flag` is 1 exactly when `cpu_cycle` >= P, so it is 1 at `cpu_cycle` = P and 0 at P-1.
- R3: When a prediction is stored and the flag is clear, a read reuses it. `rd_ready` rises on the edge that samples `stat_rd`. Coordinate changes made without `render_chg` have no effect on the result.
- R4: A computing read raises `rd_ready` for one cycle exactly PROD_W+2 clock edges after the edge that sampled `stat_rd`. PROD_W is 17 with the default parameters.
- R5: A `render_chg` pulse while the flag is clear discards the stored prediction. The next read recomputes it from the coordinates present then.
- R6: Once `hit_flag` is 1, it stays 1 until `frame_restart`, whatever `render_chg`, the coordinates or `cpu_cycle` do. Reads in that state answer on the first edge.
- R7: `frame_restart` clears `hit_flag` on the next edge, discards any prediction and cancels a computation in progress.
- R8: A read with `obj_absent` high answers on the first edge, leaves `hit_flag` at 0 and stores no prediction.
- R9: `stat_rd` pulses that arrive while a computation is running are ignored. Each accepted read yields exactly one `rd_ready` pulse.
- R10: A `render_chg` pulse during a computation restarts it with the coordinates present at the restart. The stale result is never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_cycle | input | 15 | CPU cycle count since the start of the frame |
| obj_x | input | 8 | Hit column of sprite zero |
| obj_y | input | 8 | Hit row of sprite zero |
| obj_absent | input | 1 | High when no collision can occur in this frame |
| stat_rd | input | 1 | Status-read strobe |
| render_chg | input | 1 | Mid-frame change to playfield or object rendering |
| frame_restart | input | 1 | Start of a new frame |
| rd_ready | output | 1 | One-cycle pulse when `hit_flag` is valid for the read |
| hit_flag | output | 1 | Collision flag |

## Verification
The hardest case to reach is a rendering change that lands while the divider is running. The restarted computation must replace the stale one and not race it. The bench starts a read with a far-down hit row and waits several cycles into the division. It then pulses `render_chg` with a much earlier row and holds `cpu_cycle` at the earlier prediction. If the stale result were kept, the flag would stay clear. A related case is status reads arriving mid-computation. The bench issues them at fixed offsets inside the division window and counts the `rd_ready` pulses.

// File: rtl/ozp_pkg.sv
package ozp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } ozp_state_e;

  function automatic int unsigned ozp_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ozp_rst_sync.sv
module ozp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[0] <= 1'b0;
          else         sync_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/ozp_line_mac.sv
// Forms (row + lead lines) * pixels-per-line + column as a shift-add over
// the set bits of the constant line length.
module ozp_line_mac #(
  parameter int COORD_W    = 8,
  parameter int LEAD_LINES = 21,
  parameter int LINE_PIX   = 341,
  parameter int PROD_W     = 17
) (
  input  logic [COORD_W-1:0] col_i,
  input  logic [COORD_W-1:0] row_i,
  output logic [PROD_W-1:0]  pix_o
);

  localparam int LPW = $clog2(LINE_PIX + 1);

  logic [PROD_W-1:0] row_ext;
  logic [PROD_W-1:0] sum;

  always_comb begin
    row_ext = PROD_W'(row_i) + PROD_W'(LEAD_LINES);
    sum     = PROD_W'(col_i);
    for (int i = 0; i < LPW; i++) begin
      if (((LINE_PIX >> i) & 1) == 1) begin
        sum = sum + (row_ext << i);
      end
    end
  end

  assign pix_o = sum;

endmodule

// File: rtl/ozp_div_const.sv
// Bit-serial restoring divider by a constant: one quotient bit per cycle.
module ozp_div_const #(
  parameter int W       = 17,
  parameter int DIVISOR = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);

  localparam int REM_W = $clog2(DIVISOR) + 1;
  localparam int CNT_W = $clog2(W + 1);

  logic             busy_q, busy_nx;
  logic             done_q, done_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [W-1:0]     dvd_q, dvd_nx;
  logic [W-1:0]     quo_q, quo_nx;
  logic [REM_W-1:0] rem_q, rem_nx;
  logic [REM_W:0]   rem_sh;
  logic             take;

  always_comb begin
    busy_nx = busy_q;
    done_nx = 1'b0;
    cnt_nx  = cnt_q;
    dvd_nx  = dvd_q;
    quo_nx  = quo_q;
    rem_nx  = rem_q;
    rem_sh  = {rem_q, dvd_q[W-1]};
    take    = (rem_sh >= (REM_W+1)'(DIVISOR));
    if (clr_i) begin
      busy_nx = 1'b0;
    end else if (start_i) begin
      busy_nx = 1'b1;
      cnt_nx  = '0;
      dvd_nx  = dvd_i;
      quo_nx  = '0;
      rem_nx  = '0;
    end else if (busy_q) begin
      rem_nx = take ? REM_W'(rem_sh - (REM_W+1)'(DIVISOR)) : REM_W'(rem_sh);
      quo_nx = {quo_q[W-2:0], take};
      dvd_nx = {dvd_q[W-2:0], 1'b0};
      cnt_nx = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(W - 1)) begin
        busy_nx = 1'b0;
        done_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_nx;
      done_q <= done_nx;
      cnt_q  <= cnt_nx;
      dvd_q  <= dvd_nx;
      quo_q  <= quo_nx;
      rem_q  <= rem_nx;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R2: the partial remainder always stays below the divisor
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q < REM_W'(DIVISOR));

  // R4: completion is a single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/ozp_ctrl.sv
module ozp_ctrl
  import ozp_pkg::*;
#(
  parameter int CYC_W  = 15,
  parameter int PROD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic              absent_i,
  input  logic              rd_i,
  input  logic              chg_i,
  input  logic              frame_i,
  input  logic              div_done_i,
  input  logic [PROD_W-1:0] div_quo_i,
  output logic              div_start_o,
  output logic              div_clr_o,
  output logic              ready_o,
  output logic              flag_o
);

  localparam int CMP_W = int'(ozp_max(CYC_W, PROD_W));

  ozp_state_e        state_q, state_nx;
  logic              flag_q, flag_nx;
  logic              valid_q, valid_nx;
  logic              ready_q, ready_nx;
  logic [PROD_W-1:0] pred_q;
  logic              pred_en;
  logic              kill;
  logic [CMP_W-1:0]  cyc_ext;
  logic              reached_old, reached_new;

  always_comb begin
    cyc_ext     = CMP_W'(cyc_i);
    reached_old = (cyc_ext >= CMP_W'(pred_q));
    reached_new = (cyc_ext >= CMP_W'(div_quo_i));
    kill        = chg_i && !flag_q;
    state_nx    = state_q;
    flag_nx     = flag_q;
    valid_nx    = valid_q;
    ready_nx    = 1'b0;
    pred_en     = 1'b0;
    div_start_o = 1'b0;
    div_clr_o   = frame_i;
    if (frame_i) begin
      state_nx = ST_IDLE;
      flag_nx  = 1'b0;
      valid_nx = 1'b0;
    end else begin
      if (kill) valid_nx = 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rd_i) begin
            if (flag_q || absent_i) begin
              ready_nx = 1'b1;
            end else if (valid_q && !kill) begin
              ready_nx = 1'b1;
              flag_nx  = reached_old;
            end else begin
              state_nx = ST_MUL;
            end
          end
        end
        ST_MUL: begin
          div_start_o = 1'b1;
          state_nx    = ST_DIV;
        end
        ST_DIV: begin
          if (kill) begin
            state_nx = ST_MUL;
          end else if (div_done_i) begin
            pred_en  = 1'b1;
            valid_nx = 1'b1;
            ready_nx = 1'b1;
            flag_nx  = reached_new;
            state_nx = ST_IDLE;
          end
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
      valid_q <= 1'b0;
      ready_q <= 1'b0;
      pred_q  <= '0;
    end else begin
      state_q <= state_nx;
      flag_q  <= flag_nx;
      valid_q <= valid_nx;
      ready_q <= ready_nx;
      if (pred_en) pred_q <= div_quo_i;
    end
  end

  assign ready_o = ready_q;
  assign flag_o  = flag_q;

  // R6: a set flag holds until the frame restarts
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !frame_i) |=> flag_q);

  // R7: frame restart clears flag and prediction and returns to idle
  a_r7_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (!flag_q && !valid_q && state_q == ST_IDLE));

  // R8: an absent sprite answers at once and never raises the flag
  a_r8_absent_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rd_i && absent_i && !flag_q && !frame_i) |=> (ready_q && !flag_q));

  // R3: a stored prediction answers on the sampling edge
  a_r3_fast_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rd_i && valid_q && !chg_i && !frame_i) |=> ready_q);

  // R9: no answer while the divider has not finished
  a_r9_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIV && !div_done_i) |=> !ready_q);

  // R10: a change during division sends the sequence back to restart
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIV && chg_i && !frame_i) |=> (state_q == ST_MUL && !ready_q));

endmodule

// File: rtl/ozp_hit_predictor.sv
module ozp_hit_predictor #(
  parameter int COORD_W     = 8,
  parameter int CYC_W       = 15,
  parameter int LINE_PIX    = 341,
  parameter int LEAD_LINES  = 21,
  parameter int DIVISOR     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CYC_W-1:0]   cpu_cycle,
  input  logic [COORD_W-1:0] obj_x,
  input  logic [COORD_W-1:0] obj_y,
  input  logic               obj_absent,
  input  logic               stat_rd,
  input  logic               render_chg,
  input  logic               frame_restart,
  output logic               rd_ready,
  output logic               hit_flag
);

  localparam int COORD_MAX = (1 << COORD_W) - 1;
  localparam int PIX_MAX   = (COORD_MAX + LEAD_LINES) * LINE_PIX + COORD_MAX;
  localparam int PROD_W    = $clog2(PIX_MAX + 1);

  logic              srst_n;
  logic [PROD_W-1:0] pix_count;
  logic              div_start, div_clr, div_done;
  logic [PROD_W-1:0] div_quo;

  ozp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ozp_line_mac #(
    .COORD_W    (COORD_W),
    .LEAD_LINES (LEAD_LINES),
    .LINE_PIX   (LINE_PIX),
    .PROD_W     (PROD_W)
  ) u_mac (
    .col_i (obj_x),
    .row_i (obj_y),
    .pix_o (pix_count)
  );

  ozp_div_const #(
    .W       (PROD_W),
    .DIVISOR (DIVISOR)
  ) u_div (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr_i   (div_clr),
    .start_i (div_start),
    .dvd_i   (pix_count),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  ozp_ctrl #(
    .CYC_W  (CYC_W),
    .PROD_W (PROD_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (srst_n),
    .cyc_i       (cpu_cycle),
    .absent_i    (obj_absent),
    .rd_i        (stat_rd),
    .chg_i       (render_chg),
    .frame_i     (frame_restart),
    .div_done_i  (div_done),
    .div_quo_i   (div_quo),
    .div_start_o (div_start),
    .div_clr_o   (div_clr),
    .ready_o     (rd_ready),
    .flag_o      (hit_flag)
  );

  // R1: the outputs are quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !srst_n |=> (!rd_ready && !hit_flag));

endmodule

// File: tb/ozp_hit_predictor_tb.sv
module ozp_hit_predictor_tb;

  localparam int CLK_NS  = 10;
  localparam int PROD_W  = 17;
  localparam int COMP_LAT = PROD_W + 2;
  localparam int NVEC = 8;
  // columns: x, y, cycle offset from predicted cycle
  localparam int VEC [NVEC][3] = '{
    '{0,   0,    0},
    '{0,   0,   -1},
    '{2,   0,    0},
    '{3,   0,   -1},
    '{255, 239,  0},
    '{255, 239, -1},
    '{128, 93,   5},
    '{77,  200, 1000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] cpu_cycle;
  logic [7:0]  obj_x, obj_y;
  logic        obj_absent, stat_rd, render_chg, frame_restart;
  logic        rd_ready, hit_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  ozp_hit_predictor u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_cycle     (cpu_cycle),
    .obj_x         (obj_x),
    .obj_y         (obj_y),
    .obj_absent    (obj_absent),
    .stat_rd       (stat_rd),
    .render_chg    (render_chg),
    .frame_restart (frame_restart),
    .rd_ready      (rd_ready),
    .hit_flag      (hit_flag)
  );

  function automatic int pred_of(input int x, input int y);
    return ((y + 21) * 341 + x) / 3;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_read(output int lat);
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    lat = 0;
    while (!rd_ready && lat < 60) begin
      step();
      lat++;
    end
  endtask

  task automatic new_frame();
    frame_restart = 1'b1;
    step();
    frame_restart = 1'b0;
  endtask

  task automatic pulse_chg();
    render_chg = 1'b1;
    step();
    render_chg = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    int p;
    rst_n = 1'b0;
    cpu_cycle = '0; obj_x = '0; obj_y = '0;
    obj_absent = 1'b0; stat_rd = 1'b0; render_chg = 1'b0; frame_restart = 1'b0;
    repeat (3) step();
    // R1: reset state
    chk(hit_flag == 1'b0, "R1 flag", int'(hit_flag), 0);
    chk(rd_ready == 1'b0, "R1 ready", int'(rd_ready), 0);
    rst_n = 1'b1;
    repeat (4) step();

    // R2/R3/R4: vector table
    for (int v = 0; v < NVEC; v++) begin
      new_frame();
      p = pred_of(VEC[v][0], VEC[v][1]);
      obj_x = 8'(VEC[v][0]);
      obj_y = 8'(VEC[v][1]);
      cpu_cycle = 15'(p + VEC[v][2]);
      do_read(lat);
      chk(lat == COMP_LAT, "R4 latency", lat, COMP_LAT);
      chk(hit_flag == (VEC[v][2] >= 0), "R2 flag", int'(hit_flag), int'(VEC[v][2] >= 0));
      // R3: coordinates moved without a change strobe are not used
      obj_x = 8'd0;
      obj_y = 8'd255;
      cpu_cycle = 15'(p);
      do_read(lat);
      chk(lat == 0, "R3 latency", lat, 0);
      chk(hit_flag == 1'b1, "R3 flag", int'(hit_flag), 1);
    end

    // R5: change discards prediction
    new_frame();
    obj_x = 8'd0; obj_y = 8'd50; cpu_cycle = 15'd0;
    do_read(lat);
    chk(hit_flag == 1'b0, "R5 first flag", int'(hit_flag), 0);
    obj_y = 8'd10;
    pulse_chg();
    cpu_cycle = 15'(pred_of(0, 10));
    do_read(lat);
    chk(lat == COMP_LAT, "R5 recompute latency", lat, COMP_LAT);
    chk(hit_flag == 1'b1, "R5 new flag", int'(hit_flag), 1);

    // R6: sticky flag
    obj_y = 8'd200;
    pulse_chg();
    cpu_cycle = 15'd0;
    chk(hit_flag == 1'b1, "R6 after change", int'(hit_flag), 1);
    do_read(lat);
    chk(lat == 0, "R6 latency", lat, 0);
    chk(hit_flag == 1'b1, "R6 flag", int'(hit_flag), 1);

    // R7: frame restart clears flag and prediction
    new_frame();
    chk(hit_flag == 1'b0, "R7 flag cleared", int'(hit_flag), 0);
    obj_y = 8'd0; obj_x = 8'd0; cpu_cycle = 15'd0;
    do_read(lat);
    chk(lat == COMP_LAT, "R7 prediction gone", lat, COMP_LAT);
    chk(hit_flag == 1'b0, "R7 flag", int'(hit_flag), 0);

    // R8: absent sprite never flags and stores nothing
    new_frame();
    obj_absent = 1'b1;
    cpu_cycle = 15'h7fff;
    do_read(lat);
    chk(lat == 0, "R8 latency", lat, 0);
    chk(hit_flag == 1'b0, "R8 flag", int'(hit_flag), 0);
    obj_absent = 1'b0;
    do_read(lat);
    chk(lat == COMP_LAT, "R8 nothing stored", lat, COMP_LAT);
    chk(hit_flag == 1'b1, "R8 later flag", int'(hit_flag), 1);

    // R9: reads during computation are ignored
    begin
      int pulses;
      new_frame();
      obj_x = 8'd40; obj_y = 8'd60; cpu_cycle = 15'd0;
      stat_rd = 1'b1;
      step();
      stat_rd = 1'b0;
      pulses = 0;
      for (int k = 0; k < 40; k++) begin
        stat_rd = (k == 3 || k == 6 || k == 9);
        step();
        if (rd_ready) pulses++;
      end
      stat_rd = 1'b0;
      chk(pulses == 1, "R9 ready pulses", pulses, 1);
      chk(hit_flag == 1'b0, "R9 flag", int'(hit_flag), 0);
    end

    // R10: change during computation restarts with new coordinates
    new_frame();
    obj_x = 8'd0; obj_y = 8'd200;
    cpu_cycle = 15'(pred_of(0, 10));
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    repeat (6) step();
    obj_y = 8'd10;
    render_chg = 1'b1;
    step();
    render_chg = 1'b0;
    lat = 0;
    while (!rd_ready && lat < 60) begin
      step();
      lat++;
    end
    chk(rd_ready == 1'b1, "R10 ready", int'(rd_ready), 1);
    chk(hit_flag == 1'b1, "R10 flag", int'(hit_flag), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule